// File: doc/BRIEF.md
# Serial Configuration Loader

This block pushes a configuration bitstream into a target programmable device over a one-bit slave serial port. A one-cycle start pulse begins a load: the block pulls the active-low program pin, waits for the target to drop its active-low init pin, holds program a little longer, then releases it and waits for init to be released. Bytes then arrive on a valid/ready stream with a last flag. Each byte is shifted out most significant bit first on the serial data pin, and the target captures each bit on the rising edge of the configuration clock.

Before each byte is taken, the block checks for the target's in-load error indication (init active while done is still low) and aborts at once if it is present. After the byte marked last, the block holds the data pin high and keeps toggling the configuration clock until the target raises done. Every wait on the target is bounded by a timeout counted in system clocks, and a result code tells the failure causes apart. A readback request is refused at once, because the serial port cannot read configuration data back.

States: IDLE (reset), PROG (program low, waiting for init low), PDLY (program held for a fixed delay), REL (program released, waiting for init high), FETCH (byte check and handshake), BLO and BHI (low and high halves of one bit clock), FLO and FHI (low and high halves of a trailing clock with data high), OK and FAIL (result held). Transitions: IDLE/OK/FAIL to PROG on start, and to FAIL on a readback request; PROG to PDLY on init low, or to FAIL on timeout; PDLY to REL when the delay ends; REL to FETCH on init high, or to FAIL on timeout; FETCH to FAIL on an in-load error, or to BLO on an accepted byte; BLO to BHI and BHI to BLO at the end of each half period; BHI to FETCH after the eighth bit, or to FLO if that byte was the last; FLO and FHI alternate each half period, go to OK when done is high, and go to FAIL on timeout.

Top module: `cfg_ser_loader`

## Requirements
- R1: A start pulse seen while not busy drives prog_n_o low on the next cycle; prog_n_o stays low until init_n_i is seen low and then for exactly PROG_DLY_CYC more cycles, and the configuration clock stays low throughout.
- R2: If init_n_i is not low within TIMEOUT_CYC cycles of prog_n_o falling, the load ends in FAIL with err_o = 1, fail_o rising TIMEOUT_CYC cycles after prog_n_o falls.
- R3: After prog_n_o is released the block waits for init_n_i high; if that does not happen within TIMEOUT_CYC cycles the load ends in FAIL with err_o = 2.
- R4: Each configuration clock high phase lasts HALF_CYC system cycles, the low phase of a bit lasts HALF_CYC cycles, and din_o changes only when cclk_o was low in the previous cycle and is low in the current one.
- R5: Every accepted byte produces exactly eight rising cclk_o edges carrying its bits from bit 7 down to bit 0; s_ready_o is high only between bytes, with cclk_o low and the program pin released.
- R6: If init_n_i is low while done_i is low when a byte is about to be taken, the load ends in FAIL with err_o = 3, that byte is not accepted and no further clock edge is produced.
- R7: After the last byte, din_o is 1 on every further rising edge of cclk_o, and clocking continues until done_i is high, after which done_o is 1 with err_o = 0.
- R8: If done_i does not go high within TIMEOUT_CYC cycles of the trailing clocks starting, the load ends in FAIL with err_o = 4.
- R9: A readback request (rb_req_i high without start_i) while not busy gives fail_o = 1 with err_o = 5 on the next cycle, leaving prog_n_o high and cclk_o low.
- R10: done_o, fail_o and err_o hold until the next start or readback request; done_o and fail_o are never both high, and start_i wins when both requests arrive together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a load |
| rb_req_i | input | 1 | One-cycle readback request (always refused) |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte is valid |
| s_last_i | input | 1 | Stream byte is the final one |
| s_ready_o | output | 1 | Block takes the byte in this cycle when valid |
| prog_n_o | output | 1 | Active-low program pin to the target |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data to the target |
| init_n_i | input | 1 | Active-low init pin from the target |
| done_i | input | 1 | Done pin from the target |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | Last load finished successfully |
| fail_o | output | 1 | Last request failed |
| err_o | output | 3 | 0 none, 1 init never active, 2 init never released, 3 in-load error, 4 done never high, 5 readback refused |

## Verification
A wrong bit counter or shift order shows at the pins within one byte: the bench records din_o at every rising cclk_o and compares a sweep over all 256 byte values with the bit-by-bit expectation, so a slip surfaces as a wrong bit or a wrong edge count before the next handshake. A wrong phase counter shows as a high phase of the wrong length or a data change while the clock is high, caught on the cycle it happens. A wrong wait timer or error mux shows as a fail arriving at the wrong cycle or with the wrong code, measured against the cycle prog_n_o fell.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_PDLY,
        ST_REL,
        ST_FETCH,
        ST_BLO,
        ST_BHI,
        ST_FLO,
        ST_FHI,
        ST_OK,
        ST_FAIL
    } ld_state_e;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_INIT_ENTER = 3'd1,
        ERR_INIT_EXIT  = 3'd2,
        ERR_CRC        = 3'd3,
        ERR_DONE       = 3'd4,
        ERR_NO_RB      = 3'd5
    } ld_err_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/cfg_ser_count.sv
module cfg_ser_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_ser_shift.sv
module cfg_ser_shift
    import cfg_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] data,
    input  logic              step,
    output logic              msb,
    output logic              last_bit
);

    localparam int IW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh_q;
    logic [IW-1:0]     idx_q;

    // bit position counts down and wraps after the final bit of a byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= data;
            idx_q <= IW'(BYTE_W - 1);
        end else if (step) begin
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
            idx_q <= idx_q - 1'b1;
        end
    end

    assign msb      = sh_q[BYTE_W-1];
    assign last_bit = (idx_q == '0);

endmodule

// File: rtl/cfg_ser_loader.sv
module cfg_ser_loader
    import cfg_ser_pkg::*;
#(
    parameter int TIMEOUT_CYC  = 1000000,
    parameter int HALF_CYC     = 4,
    parameter int PROG_DLY_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       rb_req_i,
    input  logic [7:0] s_data_i,
    input  logic       s_valid_i,
    input  logic       s_last_i,
    output logic       s_ready_o,
    output logic       prog_n_o,
    output logic       cclk_o,
    output logic       din_o,
    input  logic       init_n_i,
    input  logic       done_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       fail_o,
    output logic [2:0] err_o
);

    // a half period below two cycles would let data move with the rising clock
    localparam int HALF_EFF = (HALF_CYC < 2) ? 2 : HALF_CYC;
    localparam int DLY_EFF  = (PROG_DLY_CYC < 1) ? 1 : PROG_DLY_CYC;
    localparam int TO_EFF   = (TIMEOUT_CYC < 1) ? 1 : TIMEOUT_CYC;
    localparam int PMAX     = (HALF_EFF > DLY_EFF) ? HALF_EFF : DLY_EFF;
    localparam int PW       = $clog2(PMAX + 1);
    localparam int TW       = $clog2(TO_EFF + 1);

    ld_state_e   state_q, state_d;
    ld_err_e     err_q, err_d;
    logic        last_q;
    logic        din_q;

    logic [PW-1:0] phase_cnt, phase_lim;
    logic [TW-1:0] wait_cnt;
    logic          phase_end, wait_end, in_wait, phase_clr;
    logic          crc_hit, take;
    logic          bit_msb, bit_last, bit_step;

    assign in_wait   = (state_q == ST_PROG) || (state_q == ST_REL) ||
                       (state_q == ST_FLO)  || (state_q == ST_FHI);
    assign phase_lim = (state_q == ST_PDLY) ? PW'(DLY_EFF - 1) : PW'(HALF_EFF - 1);
    assign phase_end = (phase_cnt == phase_lim);
    assign wait_end  = (wait_cnt == TW'(TO_EFF - 1));
    assign crc_hit   = !init_n_i && !done_i;
    assign take      = (state_q == ST_FETCH) && !crc_hit && s_valid_i;
    assign bit_step  = (state_q == ST_BHI) && phase_end;
    assign phase_clr = (state_d != state_q);

    cfg_ser_count #(.W(PW)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_clr),
        .cnt   (phase_cnt)
    );

    cfg_ser_count #(.W(TW)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_wait),
        .cnt   (wait_cnt)
    );

    cfg_ser_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .data     (s_data_i),
        .step     (bit_step),
        .msb      (bit_msb),
        .last_bit (bit_last)
    );

    // next state and result code
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        unique case (state_q)
            ST_IDLE, ST_OK, ST_FAIL: begin
                if (start_i) begin
                    state_d = ST_PROG;
                    err_d   = ERR_NONE;
                end else if (rb_req_i) begin
                    state_d = ST_FAIL;
                    err_d   = ERR_NO_RB;
                end
            end
            ST_PROG: begin
                if (!init_n_i) begin
                    state_d = ST_PDLY;
                end else if (wait_end) begin
                    state_d = ST_FAIL;
                    err_d   = ERR_INIT_ENTER;
                end
            end
            ST_PDLY: begin
                if (phase_end) state_d = ST_REL;
            end
            ST_REL: begin
                if (init_n_i) begin
                    state_d = ST_FETCH;
                end else if (wait_end) begin
                    state_d = ST_FAIL;
                    err_d   = ERR_INIT_EXIT;
                end
            end
            ST_FETCH: begin
                if (crc_hit) begin
                    state_d = ST_FAIL;
                    err_d   = ERR_CRC;
                end else if (s_valid_i) begin
                    state_d = ST_BLO;
                end
            end
            ST_BLO: begin
                if (phase_end) state_d = ST_BHI;
            end
            ST_BHI: begin
                if (phase_end) begin
                    if (!bit_last)   state_d = ST_BLO;
                    else if (last_q) state_d = ST_FLO;
                    else             state_d = ST_FETCH;
                end
            end
            ST_FLO, ST_FHI: begin
                if (done_i) begin
                    state_d = ST_OK;
                end else if (wait_end) begin
                    state_d = ST_FAIL;
                    err_d   = ERR_DONE;
                end else if (phase_end) begin
                    state_d = (state_q == ST_FLO) ? ST_FHI : ST_FLO;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
            last_q  <= 1'b0;
            din_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            if (take) last_q <= s_last_i;
            if (state_q == ST_BLO) din_q <= bit_msb;
            else if (state_q == ST_FLO) din_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        prog_n_o  = !((state_q == ST_PROG) || (state_q == ST_PDLY));
        cclk_o    = (state_q == ST_BHI) || (state_q == ST_FHI);
        s_ready_o = (state_q == ST_FETCH) && !crc_hit;
        busy_o    = !((state_q == ST_IDLE) || (state_q == ST_OK) || (state_q == ST_FAIL));
        done_o    = (state_q == ST_OK);
        fail_o    = (state_q == ST_FAIL);
        err_o     = err_q;
        din_o     = din_q;
    end

endmodule

// File: rtl/cfg_ser_loader_chk.sv
module cfg_ser_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       rb_req_i,
    input logic       s_ready_o,
    input logic       prog_n_o,
    input logic       cclk_o,
    input logic       din_o,
    input logic       init_n_i,
    input logic       done_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       fail_o,
    input logic [2:0] err_o
);

    AST_PROG_NO_CCLK: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> !cclk_o); // R1

    AST_DIN_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (din_o != $past(din_o)) |-> (!cclk_o && !$past(cclk_o))); // R4

    AST_RISE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $stable(din_o)); // R4

    AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (!cclk_o && prog_n_o && busy_o)); // R5

    AST_CRC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fail_o) && err_o == 3'd3) |-> $past(!init_n_i && !done_i)); // R6

    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_o == 3'd0)); // R7

    AST_RB_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req_i && !start_i && !busy_o) |=> (fail_o && err_o == 3'd5 && prog_n_o && !cclk_o)); // R9

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o)); // R10

    AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !fail_o && !done_o && !prog_n_o)); // R10

endmodule

bind cfg_ser_loader cfg_ser_loader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rb_req_i  (rb_req_i),
    .s_ready_o (s_ready_o),
    .prog_n_o  (prog_n_o),
    .cclk_o    (cclk_o),
    .din_o     (din_o),
    .init_n_i  (init_n_i),
    .done_i    (done_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .fail_o    (fail_o),
    .err_o     (err_o)
);

// File: tb/sim_cfg_ser_loader.sv
`timescale 1ns/1ps
module sim_cfg_ser_loader;

    localparam int TO   = 40;
    localparam int HALF = 2;
    localparam int PDLY = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       rb_req_i = 1'b0;
    logic [7:0] s_data_i = 8'h00;
    logic       s_valid_i = 1'b0;
    logic       s_last_i = 1'b0;
    logic       s_ready_o, prog_n_o, cclk_o, din_o;
    logic       init_n_i = 1'b1;
    logic       done_i = 1'b0;
    logic       busy_o, done_o, fail_o;
    logic [2:0] err_o;

    always #2.5 clk = ~clk;

    cfg_ser_loader #(.TIMEOUT_CYC(TO), .HALF_CYC(HALF), .PROG_DLY_CYC(PDLY)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rb_req_i(rb_req_i),
        .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_last_i(s_last_i),
        .s_ready_o(s_ready_o), .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o),
        .init_n_i(init_n_i), .done_i(done_i), .busy_o(busy_o), .done_o(done_o),
        .fail_o(fail_o), .err_o(err_o)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
            $finish;
        end
    end

    // captured serial bits
    bit bits[$];
    always @(posedge cclk_o) bits.push_back(din_o);

    // target device model
    int  m_idly = 4, m_rdly = 2, m_need = 1000000, m_crc = -1;
    int  mphase = 0, plo = 0, rel = 0, hold_cnt = 0;
    bit  released = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!prog_n_o) begin
                if (mphase != 1) begin
                    mphase = 1; plo = 0; hold_cnt = 0;
                end
                if (!init_n_i) hold_cnt++;
                plo++;
                if (m_idly >= 0 && plo >= m_idly) init_n_i = 1'b0;
                done_i = 1'b0;
            end else if (mphase == 1) begin
                mphase = 2; rel = 0; released = 0;
            end
            if (mphase == 2) begin
                rel++;
                if (!released && m_rdly >= 0 && rel >= m_rdly) begin
                    init_n_i = 1'b1; released = 1;
                end
                if (released && m_crc >= 0 && bits.size() >= m_crc) init_n_i = 1'b0;
                if (bits.size() >= m_need) done_i = 1'b1;
            end
        end
    end

    // pin timing monitor
    int  hi_run = 0, hi_runs = 0, hi_bad = 0, din_bad = 0;
    logic prev_c = 1'b0, prev_d = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cclk_o) hi_run++;
            else begin
                if (hi_run > 0) begin
                    if (busy_o && hi_run != HALF) hi_bad++;
                    hi_runs++;
                end
                hi_run = 0;
            end
            if (din_o != prev_d && (cclk_o || prev_c)) din_bad++;
        end
        prev_c = cclk_o;
        prev_d = din_o;
    end

    function automatic logic [7:0] pat(input int mode, input int k);
        if (mode == 0) return k[7:0];
        case (k % 5)
            0: return 8'h80;
            1: return 8'h01;
            2: return 8'h5A;
            3: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start_i = 0; rb_req_i = 0; s_valid_i = 0; s_last_i = 0;
        init_n_i = 1'b1; done_i = 1'b0; mphase = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    int lat;
    int acc;

    task automatic run_load(input int n, input int mode, input int gap, input int extra,
                            input int idly, input int rdly, input int crcat);
        m_idly = idly; m_rdly = rdly; m_crc = crcat; m_need = 8 * n + extra;
        bits.delete();
        acc = 0;
        lat = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        fork
            begin
                for (int k = 0; k < n; k++) begin
                    bit stop = 0;
                    s_data_i = pat(mode, k);
                    s_last_i = (k == n - 1);
                    s_valid_i = 1'b1;
                    forever begin
                        if (s_ready_o) break;
                        if (fail_o || done_o) begin stop = 1; break; end
                        @(negedge clk);
                    end
                    if (stop) begin s_valid_i = 1'b0; break; end
                    @(posedge clk); #1;
                    s_valid_i = 1'b0;
                    acc++;
                    repeat (gap) @(negedge clk);
                end
            end
            begin
                while (!(done_o || fail_o) && lat < 30000) begin
                    @(negedge clk);
                    lat++;
                end
            end
        join
        s_valid_i = 1'b0;
    endtask

    task automatic check_bits(input int n, input int mode, input string tag);
        int bad = 0;
        for (int k = 0; k < n; k++)
            for (int j = 0; j < 8; j++)
                if (8 * k + j >= bits.size() || bits[8 * k + j] != pat(mode, k)[7 - j]) bad++;
        chk(bad == 0, {tag, " R5 bit order"}, bad, 0);
        bad = 0;
        for (int i = 8 * n; i < bits.size(); i++) if (!bits[i]) bad++;
        chk(bad == 0 && bits.size() > 8 * n, {tag, " R7 trailing ones"}, bad, 0);
    endtask

    initial begin
        do_reset();
        // reset state
        chk(prog_n_o && !cclk_o && !busy_o && !done_o && !fail_o && err_o == 0 && !s_ready_o,
            "reset idle", {prog_n_o, cclk_o, busy_o, done_o, fail_o}, 5'b10000);

        // sweep of every byte value
        run_load(256, 0, 0, 3, 4, 2, -1);
        chk(done_o && !fail_o && err_o == 0, "R7 done after sweep", err_o, 0);
        chk(acc == 256, "R5 bytes taken", acc, 256);
        check_bits(256, 0, "sweep");
        chk(hold_cnt == PDLY, "R1 program hold after init", hold_cnt, PDLY);
        chk(hi_bad == 0 && hi_runs > 2000, "R4 high phase length", hi_bad, 0);
        chk(din_bad == 0, "R4 data moves with clock low", din_bad, 0);

        // results hold, start beats readback
        repeat (30) @(negedge clk);
        chk(done_o && !busy_o && err_o == 0, "R10 done held", done_o, 1);
        start_i = 1'b1; rb_req_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; rb_req_i = 1'b0;
        chk(busy_o && !fail_o && !done_o && !prog_n_o, "R10 start priority", busy_o, 1);

        // patterned bytes with stream gaps
        do_reset();
        run_load(10, 1, 5, 2, 7, 5, -1);
        chk(done_o && err_o == 0, "R7 done with gaps", err_o, 0);
        check_bits(10, 1, "gaps");
        chk(hold_cnt == PDLY, "R1 program hold second", hold_cnt, PDLY);

        // init never goes active
        do_reset();
        run_load(2, 1, 0, 2, -1, 2, -1);
        chk(fail_o && err_o == 1, "R2 init enter timeout code", err_o, 1);
        chk(lat == TO, "R2 timeout latency", lat, TO);
        chk(bits.size() == 0, "R2 no clocks", bits.size(), 0);

        // init never released
        do_reset();
        run_load(2, 1, 0, 2, 3, -1, -1);
        chk(fail_o && err_o == 2, "R3 init release timeout code", err_o, 2);
        chk(prog_n_o && bits.size() == 0, "R3 program released", bits.size(), 0);

        // in-load error during the second byte
        do_reset();
        run_load(4, 1, 0, 2, 3, 2, 12);
        chk(fail_o && err_o == 3, "R6 in-load error code", err_o, 3);
        chk(acc == 2, "R6 bytes taken before abort", acc, 2);
        repeat (10) @(negedge clk);
        chk(bits.size() == 16, "R6 clock stops", bits.size(), 16);
        chk(fail_o && err_o == 3, "R10 fail held", err_o, 3);

        // done never rises
        do_reset();
        run_load(1, 1, 0, 100000, 3, 2, -1);
        chk(fail_o && err_o == 4, "R8 done timeout code", err_o, 4);
        chk(bits.size() > 8, "R8 trailing clocks ran", bits.size(), 9);

        // readback refused
        do_reset();
        bits.delete();
        rb_req_i = 1'b1;
        @(negedge clk);
        rb_req_i = 1'b0;
        chk(fail_o && err_o == 5, "R9 readback refused", err_o, 5);
        chk(prog_n_o && !cclk_o && !busy_o, "R9 pins untouched", prog_n_o, 1);
        repeat (10) @(negedge clk);
        chk(fail_o && err_o == 5 && bits.size() == 0, "R10 readback result held", err_o, 5);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule